// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt pins (four by default) and turns pin activity into interrupt requests. Every pin is first brought into the clock domain by a two-stage synchronizer. A per-channel detector then compares the current sample with the previous one. A two-bit sense field per channel selects the trigger: held-low level, any change, falling edge or rising edge. The edge modes set a sticky flag. The level mode does not latch anything. Its request follows the synchronized pin for as long as the pin stays low.

Requests reach the outputs only when the global interrupt enable and the channel's mask bit are both high. Software reaches three registers through a small register port: the packed sense-control byte, the mask and the flag. A flag is cleared by writing 1 to it or by a per-channel acknowledge pulse. An edge event in the same cycle as a clear wins over the clear. Edge recording needs the I/O clock enable to be high. The block does not look at pin direction, so a pin that the chip itself drives can raise a software interrupt.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the sense-control, mask and flag registers all read 0 and every `irq_o` bit is 0.
- R2: Address 0 is the sense-control byte, which is read/write. Channel n uses bits 2n+1:2n, so channel 3 is in bits 7:6 and channel 0 is in bits 1:0. Address 1 is the mask, with bit n for channel n. Address 2 is the flag register, with bit n for channel n.
- R3: `irq_o[n]` can be 1 only when `gie_i` is 1 and mask bit n is 1.
- R4: Sense code 00 (level) holds the request while the synchronized pin is low and drops it once the pin is high again. It never sets the flag.
- R5: Sense code 01 sets the flag on any change of the sampled pin, either falling or rising.
- R6: Sense code 10 sets the flag only on a falling edge. Sense code 11 sets it only on a rising edge. The opposite edge leaves the flag at 0.
- R7: A flag clears on an `ack_i` pulse or on a write of 1 to its bit at address 2. An edge event in the same cycle as the clear leaves the flag set.
- R8: While `io_clk_en_i` is 0, pin edges set no flag, and those edges are not recorded later when the enable returns.
- R9: A pin level held for two clock periods is captured. An edge that is applied just after a clock edge shows in the flag after the third following rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_clk_en_i | input | 1 | I/O clock running; edge events are dropped while this is low |
| pin_i | input | 4 | External interrupt pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 4 | Per-channel flag clear on acknowledge |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 sense control, 1 mask, 2 flag |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on address |
| irq_o | output | 4 | Gated per-channel interrupt requests |

## Verification
The bench drives a clear pulse in exactly the cycle the edge event is seen. A design that gave the clear priority would lose that interrupt, and the flag would read 0. It checks that the flag is still 0 one cycle before the three-edge latency is reached and 1 at that point. It also checks that level mode drops its request after the pin goes high and leaves no flag behind, which catches a design that latches the level. Edges made while the I/O clock enable is low must not show up once the enable returns, which catches a design whose history register keeps stale samples. The bench also applies the wrong edge in each single-edge mode, and checks that the mask and global enable suppress a flag that is already set.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // reset to idle-high so a quiet pin produces no event after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CTRL_W = 2 * NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] flag_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] w1c_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NUM_CH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (addr_i == ADDR_MASK) mask_q <= wdata_i[NUM_CH-1:0];
    end
  end

  assign w1c_o  = (we_i && addr_i == ADDR_FLAG) ? wdata_i[NUM_CH-1:0] : '0;
  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      ADDR_MASK: rdata_o[NUM_CH-1:0] = mask_q;
      ADDR_FLAG: rdata_o[NUM_CH-1:0] = flag_i;
      default:   rdata_o = '0;
    endcase
  end

  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_CTRL) |=> ctrl_q == $past(wdata_i[CTRL_W-1:0]));
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   io_en_i,
  input  logic   sync_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  output logic   flag_o,
  output logic   req_o
);
  logic prev_q, flag_q, edge_evt;

  // history runs regardless of io_en_i so gated edges are lost, not deferred
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_i;
  end

  always_comb begin
    unique case (sense_i)
      SENSE_ANY:  edge_evt = sync_i ^ prev_q;
      SENSE_FALL: edge_evt = prev_q & ~sync_i;
      SENSE_RISE: edge_evt = ~prev_q & sync_i;
      default:    edge_evt = 1'b0;
    endcase
    edge_evt = edge_evt & io_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (edge_evt) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign req_o  = (sense_i == SENSE_LOW) ? ~sync_i : flag_q;

  p_edge_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_evt && clr_i) |=> flag_q);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !edge_evt) |=> !flag_q);
  p_gated_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_en_i && !clr_i) |=> flag_q == $past(flag_q));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_clk_en_i,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              gie_i,
  input  logic [NUM_CH-1:0] ack_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int unsigned CTRL_W = 2 * NUM_CH;

  logic [NUM_CH-1:0] pin_sync, flag, req, mask, w1c;
  logic [CTRL_W-1:0] ctrl;

  ext_irq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync)
  );

  ext_irq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flag_i(flag), .rdata_o(reg_rdata_o),
    .ctrl_o(ctrl), .mask_o(mask), .w1c_o(w1c)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ext_irq_chan i_chan (
      .clk_i, .rst_ni,
      .io_en_i(io_clk_en_i),
      .sync_i(pin_sync[c]),
      .sense_i(sense_e'(ctrl[2*c +: 2])),
      .clr_i(ack_i[c] | w1c[c]),
      .flag_o(flag[c]),
      .req_o(req[c])
    );
  end

  assign irq_o = req & mask & {NUM_CH{gie_i}};

  p_gie_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> irq_o == '0);
  p_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~mask) == '0);
endmodule

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 0, rst_n = 0, io_en = 1, gie = 0, we = 0;
  logic [N-1:0] pin = '1, ack = '0, irq;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_sense i_ext_irq_sense (
    .clk_i(clk), .rst_ni(rst_n), .io_clk_en_i(io_en), .pin_i(pin),
    .gie_i(gie), .ack_i(ack), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 mask", v, 0);
    rd(2, v); check("R1 flag", v, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    // ch3=rise ch2=fall ch1=any ch0=level
    wr(0, 8'hE4); rd(0, v); check("R2 ctrl readback", v, 8'hE4);
    wr(1, 8'h0F); rd(1, v); check("R2 mask readback", v, 8'h0F);
  endtask

  task automatic t_level;
    logic [7:0] v;
    gie = 1;
    pin[0] = 0; cycles(4);
    check("R4 level active", irq[0], 1);
    rd(2, v); check("R4 level no flag", v[0], 0);
    pin[0] = 1; cycles(4);
    check("R4 level released", irq[0], 0);
  endtask

  task automatic t_any;
    logic [7:0] v;
    pin[1] = 0; cycles(4);
    rd(2, v); check("R5 any fall", v[1], 1);
    check("R5 irq", irq[1], 1);
    wr(2, 8'h02); rd(2, v); check("R7 w1c clear", v[1], 0);
    pin[1] = 1; cycles(4);
    rd(2, v); check("R5 any rise", v[1], 1);
    ack[1] = 1; cycles(1); ack[1] = 0;
    rd(2, v); check("R7 ack clear", v[1], 0);
  endtask

  task automatic t_edges;
    logic [7:0] v;
    pin[3] = 0; cycles(4);
    rd(2, v); check("R6 rise ignores fall", v[3], 0);
    // latency: edge after the third clock edge
    pin[2] = 0; cycles(2);
    rd(2, v); check("R9 not before third edge", v[2], 0);
    cycles(1);
    rd(2, v); check("R9 at third edge", v[2], 1);
    wr(2, 8'h04);
    pin[2] = 1; pin[3] = 1; cycles(4);
    rd(2, v); check("R6 fall ignores rise", v[2], 0);
    check("R6 rise detected", v[3], 1);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    gie = 0; cycles(1);
    check("R3 gie off", irq, 0);
    gie = 1; wr(1, 8'h07); cycles(1);
    check("R3 mask off", irq[3], 0);
    rd(2, v); check("R3 flag kept", v[3], 1);
    wr(1, 8'h0F); cycles(1);
    check("R3 enabled", irq[3], 1);
    wr(2, 8'h0F);
  endtask

  task automatic t_race;
    logic [7:0] v;
    pin[1] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); ack[1] = 1;
    @(posedge clk); @(negedge clk); ack[1] = 0;
    rd(2, v); check("R7 edge beats ack", v[1], 1);
    wr(2, 8'h02);
    pin[1] = 1; repeat (2) @(posedge clk);
    @(negedge clk); we = 1; addr = 2; wdata = 8'h02;
    @(posedge clk); @(negedge clk); we = 0;
    rd(2, v); check("R7 edge beats w1c", v[1], 1);
    wr(2, 8'h0F);
  endtask

  task automatic t_gate;
    logic [7:0] v;
    io_en = 0;
    pin[2] = 0; cycles(4);
    rd(2, v); check("R8 gated no flag", v[2], 0);
    io_en = 1; cycles(4);
    rd(2, v); check("R8 not recorded later", v[2], 0);
    pin[2] = 1; cycles(4);
  endtask

  task automatic t_pulse;
    logic [7:0] v;
    pin[2] = 0; cycles(2); pin[2] = 1; cycles(4);
    rd(2, v); check("R9 two-cycle pulse caught", v[2], 1);
    check("R9 irq", irq[2], 1);
    wr(2, 8'h0F);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    t_reset();
    @(negedge clk); rst_n = 1; cycles(1);
    t_reset();
    t_regs();
    t_level();
    t_any();
    t_edges();
    t_mask();
    t_race();
    t_gate();
    t_pulse();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule